// File: doc/BRIEF.md
# Shared Instruction/Data Memory Port Arbiter

This block lets a five-stage in-order pipeline run from one memory array that has a single access port. Two requesters contend for the port. The front end fetches at the address held in the block's program counter. The memory stage issues loads and stores. A multiplexer places one of the two addresses on the port in each cycle. Read data goes either into the instruction register that feeds decode, or back to the memory stage as the load result.

When both requesters want the port in the same cycle, the memory-stage access wins because it belongs to the older instruction. Giving priority to the older access means no instruction can wait on a younger one, so deadlock cannot occur. The fetch that loses leaves a bubble in decode, and it is retried at the same program counter in the next cycle. Each conflict therefore delays every younger instruction by exactly one cycle. A store takes the port in the same way a load does.

The array is a behavioural RAM. Reads are combinational and writes are synchronous. The program counter, the instruction register and the decode valid flag are registered.

Top module: `unified_port_arbiter`

## Requirements
- R1: While reset is asserted, `fetch_pc` is `RESET_PC`, `dec_valid` is 0, and `dec_instr` and `dec_pc` are 0.
- R2: In a cycle with `fetch_req`=1 and `mem_req`=0, the word at `fetch_pc` is fetched. After the next rising edge, `dec_valid`=1, `dec_instr` holds that word, `dec_pc` holds the old `fetch_pc`, and `fetch_pc` has advanced by one word.
- R3: In a cycle with both `fetch_req`=1 and `mem_req`=1, the memory-stage access uses the port and `stall_fetch` is 1. In every other cycle `stall_fetch` is 0.
- R4: After a stalled cycle, `dec_valid` is 0 and both `fetch_pc` and `dec_instr` keep their values.
- R5: In a cycle with `mem_req`=1 and `mem_we`=1, `mem_wdata` is written at `mem_addr`. A later load or fetch of that address returns the new value.
- R6: In a cycle with `mem_req`=1 and `mem_we`=0, `mem_rdata` shows the word stored at `mem_addr` in that same cycle.
- R7: A store takes the port exactly as a load does: it stalls a coincident fetch.
- R8: A stalled fetch is retried at the same `fetch_pc` in the next cycle that grants the port to fetch.
- R9: Take a load followed by three adds, fetched back to back, with the load reaching the memory stage three cycles after its own fetch. The third add is fetched one cycle late, and decode sees exactly one bubble before it.
- R10: In a cycle with `fetch_req`=0, nothing is fetched and `stall_fetch` is 0. After the next edge, `dec_valid` is 0 and `fetch_pc` is unchanged.
- R11: `fetch_pc` wraps from the last word address to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Front end wants to fetch this cycle |
| mem_req | input | 1 | Memory stage holds a load or store |
| mem_we | input | 1 | Memory-stage access is a store |
| mem_addr | input | ADDR_W | Word address of the load or store |
| mem_wdata | input | DATA_W | Store data |
| mem_rdata | output | DATA_W | Load result; 0 unless a load is active |
| stall_fetch | output | 1 | Fetch lost the port this cycle |
| fetch_pc | output | ADDR_W | Program counter (next fetch address) |
| dec_valid | output | 1 | Decode holds a real instruction; 0 means bubble |
| dec_pc | output | ADDR_W | Address of the instruction in decode |
| dec_instr | output | DATA_W | Instruction register contents |

## Verification
The assertions assume that `fetch_req`, `mem_req` and `mem_we` are known and stable around the sampling edge. They also assume that `mem_we` has meaning only when `mem_req` is high. The bench drives every input on the falling edge and keeps all of them at defined values.

Before any fetch reads the array, the bench fills the whole array through stores with `fetch_req` low. This ensures that no undefined word ever reaches `dec_instr` or `mem_rdata`. The random phase then mixes loads and stores at about one cycle in four with fetch requests at nine in ten. This produces frequent conflicts, runs of back-to-back stalls, and program-counter wraparound.

// File: rtl/upa_pkg.sv
package upa_pkg;

    // Which requester drives the shared port in the current cycle.
    typedef enum logic [1:0] {
        OWNER_IDLE  = 2'd0,
        OWNER_FETCH = 2'd1,
        OWNER_DATA  = 2'd2
    } port_owner_e;

endpackage

// File: rtl/upa_port_mux.sv
module upa_port_mux
    import upa_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              data_req,
    input  logic              data_we,
    input  logic [ADDR_W-1:0] data_addr,
    input  logic [DATA_W-1:0] data_wdata,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              fetch_grant,
    output logic              fetch_stall
);

    port_owner_e owner;

    // The older (memory-stage) access always wins the port.
    always_comb begin
        if (data_req)       owner = OWNER_DATA;
        else if (fetch_req) owner = OWNER_FETCH;
        else                owner = OWNER_IDLE;
    end

    always_comb begin
        ram_addr    = '0;
        ram_we      = 1'b0;
        ram_wdata   = data_wdata;
        fetch_grant = 1'b0;
        unique case (owner)
            OWNER_DATA: begin
                ram_addr = data_addr;
                ram_we   = data_we;
            end
            OWNER_FETCH: begin
                ram_addr    = fetch_addr;
                fetch_grant = 1'b1;
            end
            default: ;
        endcase
        fetch_stall = fetch_req && (owner == OWNER_DATA);
    end

endmodule

// File: rtl/upa_ram.sv
module upa_ram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];

endmodule

// File: rtl/upa_fetch_ctrl.sv
module upa_fetch_ctrl #(
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 32,
    parameter logic [31:0] RESET_PC = 32'd0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_grant,
    input  logic [DATA_W-1:0] fetch_word,
    output logic [ADDR_W-1:0] pc,
    output logic              dec_valid,
    output logic [ADDR_W-1:0] dec_pc,
    output logic [DATA_W-1:0] dec_instr
);

    localparam logic [ADDR_W-1:0] PC_INIT = RESET_PC[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic              valid;
        logic [ADDR_W-1:0] dpc;
        logic [DATA_W-1:0] ir;
    } fetch_state_t;

    fetch_state_t state_d, state_q;

    // Without a grant the slot becomes a bubble: the valid flag clears
    // while the pc and the instruction register keep their values.
    always_comb begin
        state_d       = state_q;
        state_d.valid = 1'b0;
        if (fetch_grant) begin
            state_d.ir    = fetch_word;
            state_d.dpc   = state_q.pc;
            state_d.pc    = state_q.pc + PC_STEP;
            state_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.pc    <= PC_INIT;
            state_q.valid <= 1'b0;
            state_q.dpc   <= '0;
            state_q.ir    <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pc        = state_q.pc;
    assign dec_valid = state_q.valid;
    assign dec_pc    = state_q.dpc;
    assign dec_instr = state_q.ir;

endmodule

// File: rtl/unified_port_arbiter.sv
module unified_port_arbiter #(
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 32,
    parameter logic [31:0] RESET_PC = 32'd0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic              mem_req,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] mem_rdata,
    output logic              stall_fetch,
    output logic [ADDR_W-1:0] fetch_pc,
    output logic              dec_valid,
    output logic [ADDR_W-1:0] dec_pc,
    output logic [DATA_W-1:0] dec_instr
);

    logic              ram_we;
    logic [ADDR_W-1:0] ram_addr;
    logic [DATA_W-1:0] ram_wdata;
    logic [DATA_W-1:0] ram_rdata;
    logic              fetch_grant;
    logic [ADDR_W-1:0] pc;

    upa_port_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
        .fetch_req   (fetch_req),
        .fetch_addr  (pc),
        .data_req    (mem_req),
        .data_we     (mem_we),
        .data_addr   (mem_addr),
        .data_wdata  (mem_wdata),
        .ram_we      (ram_we),
        .ram_addr    (ram_addr),
        .ram_wdata   (ram_wdata),
        .fetch_grant (fetch_grant),
        .fetch_stall (stall_fetch)
    );

    upa_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    upa_fetch_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RESET_PC(RESET_PC)) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_grant (fetch_grant),
        .fetch_word  (ram_rdata),
        .pc          (pc),
        .dec_valid   (dec_valid),
        .dec_pc      (dec_pc),
        .dec_instr   (dec_instr)
    );

    // Load data is steered back only while a load owns the port.
    assign mem_rdata = (mem_req && !mem_we) ? ram_rdata : '0;
    assign fetch_pc  = pc;

endmodule

// File: rtl/upa_checker.sv
module upa_checker #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_req,
    input logic              mem_req,
    input logic              stall_fetch,
    input logic [ADDR_W-1:0] fetch_pc,
    input logic              dec_valid,
    input logic [ADDR_W-1:0] dec_pc,
    input logic [DATA_W-1:0] dec_instr
);

    assert_conflict_stalls_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && mem_req) |-> stall_fetch);

    assert_stall_needs_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stall_fetch |-> (mem_req && fetch_req));

    assert_bubble_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stall_fetch |=> (!dec_valid && $stable(fetch_pc) && $stable(dec_instr)));

    assert_fetch_advances_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !mem_req) |=>
            (dec_valid && dec_pc == $past(fetch_pc)
             && fetch_pc == ADDR_W'($past(fetch_pc) + 1'b1)));

    assert_idle_no_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_req |=> (!dec_valid && $stable(fetch_pc)));

endmodule

bind unified_port_arbiter upa_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_req   (fetch_req),
    .mem_req     (mem_req),
    .stall_fetch (stall_fetch),
    .fetch_pc    (fetch_pc),
    .dec_valid   (dec_valid),
    .dec_pc      (dec_pc),
    .dec_instr   (dec_instr)
);

// File: tb/tb_unified_port_arbiter.sv
`timescale 1ns/1ps
module tb_unified_port_arbiter;

    localparam int AW    = 8;
    localparam int DW    = 32;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fetch_req = 1'b0;
    logic          mem_req = 1'b0;
    logic          mem_we = 1'b0;
    logic [AW-1:0] mem_addr = '0;
    logic [DW-1:0] mem_wdata = '0;
    logic [DW-1:0] mem_rdata;
    logic          stall_fetch;
    logic [AW-1:0] fetch_pc;
    logic          dec_valid;
    logic [AW-1:0] dec_pc;
    logic [DW-1:0] dec_instr;

    always #4 clk = ~clk;

    unified_port_arbiter dut (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .stall_fetch(stall_fetch), .fetch_pc(fetch_pc),
        .dec_valid(dec_valid), .dec_pc(dec_pc), .dec_instr(dec_instr)
    );

    // Reference model
    logic [DW-1:0] m_mem [DEPTH];
    logic [AW-1:0] m_pc;
    logic [AW-1:0] m_dpc;
    logic [DW-1:0] m_ir;
    logic          m_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_stall(input logic f, input logic m);
        return f && m;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; fetch_req = 1'b0; mem_req = 1'b0; mem_we = 1'b0;
        @(posedge clk); #2;
        check("R1 pc", DW'(fetch_pc), '0);
        check("R1 valid", DW'(dec_valid), '0);
        check("R1 instr", dec_instr, '0);
        check("R1 dpc", DW'(dec_pc), '0);
        @(negedge clk);
        rst_n = 1'b1;
        m_pc = '0; m_dpc = '0; m_ir = '0; m_valid = 1'b0;
    endtask

    // One cycle: drive, check combinational outputs, update model, check registers.
    task automatic step(input logic f, input logic m, input logic w,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        fetch_req = f; mem_req = m; mem_we = w; mem_addr = a; mem_wdata = d;
        #1;
        check(w ? "R7 stall" : "R3 stall", DW'(stall_fetch), DW'(exp_stall(f, m)));
        if (m && !w) check("R6 load", mem_rdata, m_mem[a]);
        if (f && !m) begin
            m_ir = m_mem[m_pc]; m_dpc = m_pc; m_pc = m_pc + 1'b1; m_valid = 1'b1;
        end else begin
            m_valid = 1'b0;
        end
        if (m && w) m_mem[a] = d;
        @(posedge clk); #2;
        check(!f ? "R10 valid" : (m ? "R4 valid" : "R2 valid"), DW'(dec_valid), DW'(m_valid));
        check(m ? "R8 pc" : "R2 pc", DW'(fetch_pc), DW'(m_pc));
        check(m ? "R4 instr" : "R5 instr", dec_instr, m_ir);
        check("R2 dpc", DW'(dec_pc), DW'(m_dpc));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (2) @(posedge clk);
        do_reset();

        // Preload every word through stores with fetch idle (R5, R10).
        for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b1, 1'b1, AW'(i), $urandom);

        // Directed: load, add, add, add; load reaches memory stage on cycle 3 (R9).
        do_reset();
        step(1'b1, 1'b0, 1'b0, '0, '0);
        step(1'b1, 1'b0, 1'b0, '0, '0);
        step(1'b1, 1'b0, 1'b0, '0, '0);
        step(1'b1, 1'b1, 1'b0, 8'd40, '0);
        check("R9 bubble", DW'(dec_valid), 32'd0);
        step(1'b1, 1'b0, 1'b0, '0, '0);
        check("R9 third add valid", DW'(dec_valid), 32'd1);
        check("R9 third add pc", DW'(dec_pc), 32'd3);

        // Directed: store then load of the same word, with fetch contending (R5, R7).
        step(1'b1, 1'b1, 1'b1, 8'd7, 32'hCAFE_F00D);
        step(1'b1, 1'b1, 1'b0, 8'd7, '0);
        check("R5 readback", mem_rdata, 32'hCAFE_F00D);
        // Back-to-back stalls then retry (R8).
        step(1'b1, 1'b1, 1'b0, 8'd1, '0);
        step(1'b1, 1'b0, 1'b0, '0, '0);

        // Wraparound (R11).
        do_reset();
        for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, 1'b0, '0, '0);
        check("R11 wrap pc", DW'(fetch_pc), 32'd0);
        check("R11 wrap dpc", DW'(dec_pc), DW'(DEPTH - 1));

        // Constrained random mix.
        for (int i = 0; i < 3000; i++) begin
            step($urandom_range(0, 9) != 0, $urandom_range(0, 3) == 0,
                 $urandom_range(0, 1) == 1, AW'($urandom), $urandom);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule